// File: doc/BRIEF.md
# Power Button Override Detector

This block watches an active-low power-button input and turns it into two status flags and a pair of power-control outputs. Each fresh press (a falling edge of the synchronized input) sets a button status flag and emits a one-cycle wake pulse. No enable gates either of them. While the button stays low, a hold timer counts whole seconds using a clock prescaler. When the hold reaches the override limit, the block clears the button flag and sets a sticky override flag. It also emits a one-cycle forced-S5 request and raises a wake mask that leaves the power button as the only permitted wake source.

A rising edge on the thermal trip input triggers the same override action at once. Software clears either flag by writing a one to its bit of a two-bit write port. The override flag sits in the always-on reset domain, so the main reset does not touch it. Only the always-on reset clears it.

Top module: `pwrbtn_override_top`

## Requirements
- R1: After the main and always-on resets, `btn_sts_o`, `ovr_sts_o`, `force_s5_o`, `wake_mask_o` and `btn_wake_o` are all 0.
- R2: A high-to-low change of `btn_n_i` sets `btn_sts_o` on the third rising clock edge after the change, through a two-flop synchronizer and an edge register. No enable gates this.
- R3: Each press produces exactly one single-cycle pulse on `btn_wake_o`, in the same cycle that `btn_sts_o` first reads 1.
- R4: Writing `wr_data_i[0]`=1 with `wr_en_i` clears `btn_sts_o` on the next edge. A write with bit 0 equal to 0 leaves it unchanged.
- R5: If `btn_sts_o` is cleared while the button is still held low, it stays 0 until the button is released and pressed again.
- R6: A continuous hold of HOLD_SECS×TICKS_PER_SEC cycles, counted from the first synchronized low cycle, triggers the override on the next edge. The override sets `ovr_sts_o`, clears `btn_sts_o` and gives exactly one `force_s5_o` pulse per hold, however long the hold lasts.
- R7: A release before the limit gives no override and restarts the timer, so a new hold again needs the full limit.
- R8: A rising edge of `therm_trip_i` triggers the same override (set `ovr_sts_o`, clear `btn_sts_o`, one `force_s5_o` pulse) on the third edge after the change.
- R9: `wake_mask_o` (1 = only the power button may wake) is set by an override and stays set until `wake_i` is sampled high.
- R10: Writing `wr_data_i[1]`=1 with `wr_en_i` clears `ovr_sts_o`. Asserting `rst_n` leaves it unchanged. Only `rtc_rst_n` resets it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Main asynchronous active-low reset |
| rtc_rst_n | input | 1 | Always-on domain asynchronous active-low reset |
| btn_n_i | input | 1 | Power button, low when pressed (asynchronous) |
| therm_trip_i | input | 1 | Catastrophic thermal condition, high active (asynchronous) |
| wr_en_i | input | 1 | Status write strobe |
| wr_data_i | input | 2 | Write-one-to-clear data: bit 0 button flag, bit 1 override flag |
| wake_i | input | 1 | System has woken; releases the wake mask |
| btn_sts_o | output | 1 | Button status flag |
| ovr_sts_o | output | 1 | Override status flag |
| force_s5_o | output | 1 | One-cycle request to enter S5 |
| wake_mask_o | output | 1 | Only the power button is an enabled wake source |
| btn_wake_o | output | 1 | One-cycle wake event per press |

## Verification
The embedded assertions check on every cycle the rules that link neighbouring logic. A detected press must set the button flag unless an override coincides with it. An override must leave the button flag clear. A forced-S5 pulse only ever appears together with a set override flag. The timer fires for at most one cycle in a row, and the wake mask holds until a wake arrives. Several behaviours can only be shown by the directed scenarios:

- the exact latency through the synchronizers;
- the full hold length;
- the timer restart after an early release;
- the need for a fresh press after a clear while the button is held;
- the survival of the override flag across a main reset.

// File: rtl/pbo_pkg.sv
package pbo_pkg;
  localparam int unsigned WR_W       = 2;
  localparam int unsigned WR_BTN_BIT = 0;
  localparam int unsigned WR_OVR_BIT = 1;
  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/pbo_rst_sync.sv
module pbo_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/pbo_edge_sync.sv
module pbo_edge_sync #(
  parameter int unsigned DEPTH    = pbo_pkg::SYNC_DEPTH,
  parameter logic        IDLE_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic fall_o,
  output logic rise_o
);
  logic [DEPTH-1:0] sync_q, sync_d;
  logic             prev_q;

  always_comb begin
    sync_d = {sync_q[DEPTH-2:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {DEPTH{IDLE_VAL}};
      prev_q <= IDLE_VAL;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[DEPTH-1];
    end
  end

  assign level_o = sync_q[DEPTH-1];
  assign fall_o  = prev_q & ~sync_q[DEPTH-1];
  assign rise_o  = ~prev_q & sync_q[DEPTH-1];
endmodule

// File: rtl/pbo_hold_timer.sv
module pbo_hold_timer #(
  parameter int unsigned TICKS_PER_SEC = 1000,
  parameter int unsigned HOLD_SECS     = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic held_i,
  output logic fire_o
);
  localparam int unsigned PW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam int unsigned SW = $clog2(HOLD_SECS + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(TICKS_PER_SEC - 1);
  localparam logic [SW-1:0] SEC_LAST = SW'(HOLD_SECS - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic [SW-1:0] sec_q, sec_d;
  logic          done_q, done_d;
  logic          tick;
  logic          cnt_en;

  assign cnt_en = held_i & ~done_q;
  assign tick   = cnt_en & (pre_q == PRE_LAST);
  assign fire_o = tick & (sec_q == SEC_LAST);

  always_comb begin
    pre_d  = pre_q;
    sec_d  = sec_q;
    done_d = done_q;
    if (!held_i) begin
      pre_d  = '0;
      sec_d  = '0;
      done_d = 1'b0;
    end else if (cnt_en) begin
      pre_d = tick ? '0 : pre_q + 1'b1;
      if (tick) sec_d = sec_q + 1'b1;
      if (fire_o) done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      sec_q  <= '0;
      done_q <= 1'b0;
    end else begin
      pre_q  <= pre_d;
      sec_q  <= sec_d;
      done_q <= done_d;
    end
  end

  p_fire_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !fire_o);
  p_fire_needs_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |-> held_i);
endmodule

// File: rtl/pbo_flags.sv
module pbo_flags (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   aon_rst_n,
  input  logic                   press_i,
  input  logic                   ovr_evt_i,
  input  logic                   wr_en_i,
  input  logic [pbo_pkg::WR_W-1:0] wr_data_i,
  input  logic                   wake_i,
  output logic                   btn_sts_o,
  output logic                   ovr_sts_o,
  output logic                   force_s5_o,
  output logic                   wake_mask_o,
  output logic                   btn_wake_o
);
  import pbo_pkg::*;

  logic btn_q, btn_d;
  logic ovr_q, ovr_d;
  logic s5_q, s5_d;
  logic mask_q, mask_d;
  logic wk_q, wk_d;
  logic clr_btn, clr_ovr;

  assign clr_btn = wr_en_i & wr_data_i[WR_BTN_BIT];
  assign clr_ovr = wr_en_i & wr_data_i[WR_OVR_BIT];

  always_comb begin
    btn_d = btn_q;
    if (ovr_evt_i)    btn_d = 1'b0;
    else if (press_i) btn_d = 1'b1;
    else if (clr_btn) btn_d = 1'b0;

    ovr_d = ovr_q;
    if (ovr_evt_i)    ovr_d = 1'b1;
    else if (clr_ovr) ovr_d = 1'b0;

    mask_d = mask_q;
    if (ovr_evt_i)   mask_d = 1'b1;
    else if (wake_i) mask_d = 1'b0;

    s5_d = ovr_evt_i;
    wk_d = press_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      btn_q  <= 1'b0;
      s5_q   <= 1'b0;
      mask_q <= 1'b0;
      wk_q   <= 1'b0;
    end else begin
      btn_q  <= btn_d;
      s5_q   <= s5_d;
      mask_q <= mask_d;
      wk_q   <= wk_d;
    end
  end

  always_ff @(posedge clk or negedge aon_rst_n) begin
    if (!aon_rst_n) ovr_q <= 1'b0;
    else            ovr_q <= ovr_d;
  end

  assign btn_sts_o   = btn_q;
  assign ovr_sts_o   = ovr_q;
  assign force_s5_o  = s5_q;
  assign wake_mask_o = mask_q;
  assign btn_wake_o  = wk_q;

  p_press_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (press_i && !ovr_evt_i) |=> btn_sts_o);
  p_w1c_btn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_btn && !press_i) |=> !btn_sts_o);
  p_ovr_clears_btn_r8: assert property (@(posedge clk) disable iff (!rst_n || !aon_rst_n)
    ovr_evt_i |=> (!btn_sts_o && ovr_sts_o));
  p_s5_with_ovr_r6: assert property (@(posedge clk) disable iff (!rst_n || !aon_rst_n)
    force_s5_o |-> ovr_sts_o);
  p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_mask_o && !wake_i) |=> wake_mask_o);
endmodule

// File: rtl/pwrbtn_override_top.sv
module pwrbtn_override_top #(
  parameter int unsigned TICKS_PER_SEC = 1000,
  parameter int unsigned HOLD_SECS     = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rtc_rst_n,
  input  logic       btn_n_i,
  input  logic       therm_trip_i,
  input  logic       wr_en_i,
  input  logic [1:0] wr_data_i,
  input  logic       wake_i,
  output logic       btn_sts_o,
  output logic       ovr_sts_o,
  output logic       force_s5_o,
  output logic       wake_mask_o,
  output logic       btn_wake_o
);
  logic main_rst_n, aon_rst_n;
  logic btn_lvl, btn_fall, btn_rise_unused;
  logic th_lvl_unused, th_fall_unused, th_rise;
  logic hold_fire, ovr_evt;

  pbo_rst_sync u_main_rst (.clk(clk), .arst_n(rst_n),     .srst_n(main_rst_n));
  pbo_rst_sync u_aon_rst  (.clk(clk), .arst_n(rtc_rst_n), .srst_n(aon_rst_n));

  pbo_edge_sync #(.IDLE_VAL(1'b1)) u_btn_sync (
    .clk(clk), .rst_n(main_rst_n), .async_i(btn_n_i),
    .level_o(btn_lvl), .fall_o(btn_fall), .rise_o(btn_rise_unused)
  );

  pbo_edge_sync #(.IDLE_VAL(1'b0)) u_th_sync (
    .clk(clk), .rst_n(main_rst_n), .async_i(therm_trip_i),
    .level_o(th_lvl_unused), .fall_o(th_fall_unused), .rise_o(th_rise)
  );

  pbo_hold_timer #(.TICKS_PER_SEC(TICKS_PER_SEC), .HOLD_SECS(HOLD_SECS)) u_timer (
    .clk(clk), .rst_n(main_rst_n), .held_i(~btn_lvl), .fire_o(hold_fire)
  );

  assign ovr_evt = hold_fire | th_rise;

  pbo_flags u_flags (
    .clk(clk), .rst_n(main_rst_n), .aon_rst_n(aon_rst_n),
    .press_i(btn_fall), .ovr_evt_i(ovr_evt),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .wake_i(wake_i),
    .btn_sts_o(btn_sts_o), .ovr_sts_o(ovr_sts_o), .force_s5_o(force_s5_o),
    .wake_mask_o(wake_mask_o), .btn_wake_o(btn_wake_o)
  );
endmodule

// File: tb/pwrbtn_override_top_tb_top.sv
module pwrbtn_override_top_tb_top;
  localparam int unsigned TPS  = 8;
  localparam int unsigned HSEC = 4;
  localparam int unsigned LIM  = TPS * HSEC;

  logic       clk = 1'b0;
  logic       rst_n, rtc_rst_n, btn_n, therm, wr_en, wake;
  logic [1:0] wr_data;
  logic       btn_sts, ovr_sts, force_s5, wake_mask, btn_wake;
  int         checks = 0;
  int         errors = 0;
  int         s5_cnt = 0;
  int         wk_cnt = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  pwrbtn_override_top #(.TICKS_PER_SEC(TPS), .HOLD_SECS(HSEC)) dut_i (
    .clk(clk), .rst_n(rst_n), .rtc_rst_n(rtc_rst_n), .btn_n_i(btn_n),
    .therm_trip_i(therm), .wr_en_i(wr_en), .wr_data_i(wr_data), .wake_i(wake),
    .btn_sts_o(btn_sts), .ovr_sts_o(ovr_sts), .force_s5_o(force_s5),
    .wake_mask_o(wake_mask), .btn_wake_o(btn_wake)
  );

  always @(negedge clk) begin
    if (force_s5) s5_cnt++;
    if (btn_wake) wk_cnt++;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] d);
    wr_en = 1'b1; wr_data = d;
    step(1);
    wr_en = 1'b0; wr_data = 2'b00;
  endtask

  task automatic release_btn();
    btn_n = 1'b1;
    step(4);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; rtc_rst_n = 1'b0; btn_n = 1'b1; therm = 1'b0;
    wr_en = 1'b0; wr_data = 2'b00; wake = 1'b0;
    step(3);
    rst_n = 1'b1; rtc_rst_n = 1'b1;
    step(4);
    chk("R1", "btn_sts", btn_sts, 0);
    chk("R1", "ovr_sts", ovr_sts, 0);
    chk("R1", "force_s5", force_s5, 0);
    chk("R1", "wake_mask", wake_mask, 0);
    chk("R1", "btn_wake", btn_wake, 0);
  endtask

  task automatic t_press();
    wk_cnt = 0;
    btn_n = 1'b0;
    step(2);
    chk("R2", "btn_sts before latency", btn_sts, 0);
    step(1);
    chk("R2", "btn_sts after press", btn_sts, 1);
    chk("R3", "btn_wake pulse", btn_wake, 1);
    step(1);
    chk("R3", "btn_wake ends", btn_wake, 0);
    release_btn();
    chk("R3", "wake pulse count", wk_cnt, 1);
  endtask

  task automatic t_w1c_btn();
    wr(2'b10);
    chk("R4", "btn_sts after zero write", btn_sts, 1);
    wr(2'b01);
    chk("R4", "btn_sts after W1C", btn_sts, 0);
  endtask

  task automatic t_clear_while_held();
    btn_n = 1'b0;
    step(5);
    chk("R5", "btn_sts set", btn_sts, 1);
    wr(2'b01);
    step(6);
    chk("R5", "btn_sts stays clear while held", btn_sts, 0);
    release_btn();
    btn_n = 1'b0;
    step(3);
    chk("R5", "btn_sts on new press", btn_sts, 1);
    release_btn();
    wr(2'b01);
  endtask

  task automatic t_short_hold();
    btn_n = 1'b0;
    step(LIM - 8);
    btn_n = 1'b1;
    step(6);
    chk("R7", "no override after short hold", ovr_sts, 0);
    wr(2'b01);
    btn_n = 1'b0;
    step(LIM + 1);
    chk("R7", "timer restarted", ovr_sts, 0);
    step(1);
    chk("R7", "override after full second hold", ovr_sts, 1);
    release_btn();
    wr(2'b10);
    wake = 1'b1; step(1); wake = 1'b0;
  endtask

  task automatic t_override();
    s5_cnt = 0;
    btn_n = 1'b0;
    step(LIM + 1);
    chk("R6", "ovr_sts before limit", ovr_sts, 0);
    chk("R6", "btn_sts before limit", btn_sts, 1);
    step(1);
    chk("R6", "ovr_sts at limit", ovr_sts, 1);
    chk("R6", "btn_sts cleared", btn_sts, 0);
    chk("R6", "force_s5 pulse", force_s5, 1);
    chk("R9", "wake_mask set", wake_mask, 1);
    step(1);
    chk("R6", "force_s5 ends", force_s5, 0);
    step(3 * LIM);
    chk("R6", "single S5 pulse per hold", s5_cnt, 1);
    release_btn();
    step(10);
    chk("R9", "wake_mask held", wake_mask, 1);
    wake = 1'b1; step(1); wake = 1'b0;
    chk("R9", "wake_mask released", wake_mask, 0);
  endtask

  task automatic t_survive();
    rst_n = 1'b0; step(2); rst_n = 1'b1; step(3);
    chk("R10", "ovr_sts after main reset", ovr_sts, 1);
    wr(2'b01);
    chk("R10", "ovr_sts after bit0 write", ovr_sts, 1);
    wr(2'b10);
    chk("R10", "ovr_sts after W1C", ovr_sts, 0);
  endtask

  task automatic t_thermal();
    s5_cnt = 0;
    btn_n = 1'b0; step(4); btn_n = 1'b1; step(4);
    chk("R8", "btn_sts before trip", btn_sts, 1);
    therm = 1'b1;
    step(2);
    chk("R8", "ovr_sts before latency", ovr_sts, 0);
    step(1);
    chk("R8", "ovr_sts after trip", ovr_sts, 1);
    chk("R8", "btn_sts cleared", btn_sts, 0);
    chk("R8", "force_s5 pulse", force_s5, 1);
    step(5);
    therm = 1'b0;
    chk("R8", "one S5 pulse", s5_cnt, 1);
    rtc_rst_n = 1'b0; step(2); rtc_rst_n = 1'b1; step(3);
    chk("R10", "ovr_sts after always-on reset", ovr_sts, 0);
  endtask

  initial begin
    t_reset();
    t_press();
    t_w1c_btn();
    t_clear_while_held();
    t_override();
    t_survive();
    t_short_hold();
    t_thermal();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule